// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a flash device's bus interface and its program/erase engine. Each bus write arrives as one clock-qualified cycle that carries an address and a byte. The block reads a stream of these cycles as multi-cycle commands. Every command except the one-cycle reset starts with a fixed two-cycle unlock prefix. When a command is complete, the block reports the mode the array read path must use. For program and chip erase, it also raises a one-cycle start pulse towards the engine, together with the captured program address and data.

The engine reports back through `engBusy` and `engError`. The surrounding logic supplies two protection inputs:

- `blkProtected` covers the block addressed by the current write.
- `allProtected` is set when every block is locked.

A separate bypass mode drops the unlock prefix, so that repeated programming takes two writes per byte. Any write that breaks a sequence sends the block back to read mode quietly, without raising a flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read) and neither `progStart` nor `eraseStart` is high. The mode codes are: 0 read, 1 auto select, 2 bypass, 3 status.
- R2: The sequence 555h/AAh, 2AAh/55h, 555h/A0h, then PA/PD raises `progStart` for one cycle, in the cycle after the fourth write. In that same cycle `progAddr`=PA, `progData`=PD and `mode`=3. Once the engine drops busy without error, `mode` returns to 0.
- R3: Addresses are matched on bits 10:0 only. Bits above 10 have no effect on decoding.
- R4: In read or auto select mode, a write that does not match the expected next cycle sets `mode` to 0 and clears any partial sequence. A later fragment of that sequence then starts nothing.
- R5: Read/reset is either a single write of F0h to any address, or the unlock pair followed by F0h at any address. Either form leaves auto select mode and sets `mode` to 0.
- R6: The unlock pair followed by 555h/90h sets `mode` to 1. The mode holds while no writes occur.
- R7: The unlock pair followed by 555h/20h sets `mode` to 2. In that mode, any address with A0h followed by PA/PD starts a program, as in R2. When the program ends, `mode` is 2 again.
- R8: In mode 2, a write of 90h followed by a write of 00h, both at any address, sets `mode` to 0.
- R9: If `blkProtected` is high on the final program write, no `progStart` occurs. The mode stays at its value before the command: 0 in normal use, 2 in bypass.
- R10: While `mode` is 3 and the engine is busy, writes are ignored. No start pulse occurs and `mode` stays 3.
- R11: The six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h raise `eraseStart` for one cycle, after the sixth write only.
- R12: If `allProtected` is high on the sixth erase write, no `eraseStart` occurs. Instead `mode` reads 3 for exactly HOLD_CYC cycles and then returns to 0.
- R13: If `engError` is high when busy falls, `mode` stays 3 through later non-F0h writes, until a write of F0h. After that it returns to the mode the operation started from: 0, or 2 for a bypass program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A bus write occurs in this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data byte |
| blkProtected | input | 1 | Block addressed by the current write is protected |
| allProtected | input | 1 | Every block is protected |
| engBusy | input | 1 | Program/erase engine running |
| engError | input | 1 | Engine error, valid when busy falls |
| mode | output | 2 | 0 read, 1 auto select, 2 bypass, 3 status |
| progStart | output | 1 | One-cycle program start |
| eraseStart | output | 1 | One-cycle chip erase start |
| progAddr | output | ADDR_W | Captured program address |
| progData | output | 8 | Captured program data |

## Verification
A write presented at one rising edge updates `mode`, the start pulses and the captured program address and data before the next edge, so every result is due one cycle after its write. The bench drives each write on a falling edge, holds it for one cycle and samples the outputs on the falling edge that follows, which is exactly that one-cycle point. A fall of `engBusy` is visible on `mode` one sample later. For the protected erase, the bench counts the falling-edge samples that show status and checks that the count equals HOLD_CYC.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BYPASS  = 2'd2,
    MODE_STATUS  = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PRG, SQ_E3, SQ_E4, SQ_E5, SQ_BPRG, SQ_BRST
  } seq_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_LAUNCH, OP_RUN, OP_ERR, OP_HOLD
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchProg;
    logic holdLoad;
  } strobe_t;

  // address comparisons from datapath to control
  typedef struct packed {
    logic isLo;   // low bits equal 555h
    logic isHi;   // low bits equal 2AAh
  } match_t;

  localparam int CMP_W = 11;
  localparam logic [CMP_W-1:0] ADDR_LO = 11'h555;
  localparam logic [CMP_W-1:0] ADDR_HI = 11'h2AA;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] D_RESET   = 8'hF0;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_BYPASS  = 8'h20;
  localparam logic [7:0] D_ERASE   = 8'h80;
  localparam logic [7:0] D_ERCHIP  = 8'h10;
  localparam logic [7:0] D_BYPEXIT = 8'h00;
endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int HOLD_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  strobe_t           stb,
  output match_t            match,
  output logic              holdDone,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] holdCnt;

  // only the low address bits take part in command matching
  assign match.isLo = (wrAddr[CMP_W-1:0] == ADDR_LO);
  assign match.isHi = (wrAddr[CMP_W-1:0] == ADDR_HI);
  assign holdDone   = (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (stb.latchProg) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdCnt <= '0;
    else if (stb.holdLoad)  holdCnt <= CNT_W'(HOLD_CYC - 1);
    else if (!holdDone)     holdCnt <= holdCnt - 1'b1;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  match_t     match,
  input  logic       blkProtected,
  input  logic       allProtected,
  input  logic       engBusy,
  input  logic       engError,
  input  logic       holdDone,
  output strobe_t    stb,
  output logic [1:0] mode,
  output logic       progStart,
  output logic       eraseStart
);
  seq_e  seq, seqN;
  mode_e baseMode, baseN;
  op_e   op, opN;
  logic  progN, eraseN;

  always_comb begin
    seqN   = seq;
    baseN  = baseMode;
    opN    = op;
    progN  = 1'b0;
    eraseN = 1'b0;
    stb    = '0;
    case (op)
      OP_LAUNCH: opN = OP_RUN;
      OP_RUN:    if (!engBusy) opN = engError ? OP_ERR : OP_NONE;
      OP_ERR:    if (wrValid && wrData == D_RESET) opN = OP_NONE;
      OP_HOLD:   if (holdDone) opN = OP_NONE;
      default: begin
        if (wrValid) begin
          seqN = SQ_IDLE;
          if (baseMode == MODE_BYPASS) begin
            case (seq)
              SQ_BPRG: begin
                stb.latchProg = 1'b1;
                if (!blkProtected) begin
                  progN = 1'b1;
                  opN   = OP_LAUNCH;
                end
              end
              SQ_BRST: if (wrData == D_BYPEXIT) baseN = MODE_READ;
              default: begin
                if (wrData == D_PROG)       seqN = SQ_BPRG;
                else if (wrData == D_IDENT) seqN = SQ_BRST;
              end
            endcase
          end else begin
            baseN = MODE_READ;  // mismatch or reset falls through to read
            case (seq)
              SQ_IDLE: if (match.isLo && wrData == D_KEY1) begin
                seqN = SQ_U1; baseN = baseMode;
              end
              SQ_U1: if (match.isHi && wrData == D_KEY2) begin
                seqN = SQ_U2; baseN = baseMode;
              end
              SQ_U2: if (match.isLo) begin
                case (wrData)
                  D_IDENT:  baseN = MODE_AUTOSEL;
                  D_BYPASS: baseN = MODE_BYPASS;
                  D_PROG:   begin seqN = SQ_PRG; baseN = baseMode; end
                  D_ERASE:  begin seqN = SQ_E3;  baseN = baseMode; end
                  default:  ;
                endcase
              end
              SQ_PRG: begin
                stb.latchProg = 1'b1;
                if (!blkProtected) begin
                  progN = 1'b1;
                  opN   = OP_LAUNCH;
                end
              end
              SQ_E3: if (match.isLo && wrData == D_KEY1) begin
                seqN = SQ_E4; baseN = baseMode;
              end
              SQ_E4: if (match.isHi && wrData == D_KEY2) begin
                seqN = SQ_E5; baseN = baseMode;
              end
              SQ_E5: if (match.isLo && wrData == D_ERCHIP) begin
                if (allProtected) begin
                  opN = OP_HOLD;
                  stb.holdLoad = 1'b1;
                end else begin
                  eraseN = 1'b1;
                  opN    = OP_LAUNCH;
                end
              end
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq        <= SQ_IDLE;
      baseMode   <= MODE_READ;
      op         <= OP_NONE;
      progStart  <= 1'b0;
      eraseStart <= 1'b0;
    end else begin
      seq        <= seqN;
      baseMode   <= baseN;
      op         <= opN;
      progStart  <= progN;
      eraseStart <= eraseN;
    end
  end

  assign mode = (op != OP_NONE) ? MODE_STATUS : baseMode;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int HOLD_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              blkProtected,
  input  logic              allProtected,
  input  logic              engBusy,
  input  logic              engError,
  output logic [1:0]        mode,
  output logic              progStart,
  output logic              eraseStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData
);
  strobe_t stb;
  match_t  match;
  logic    holdDone;

  flash_cmd_dp #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .stb(stb),
    .match(match), .holdDone(holdDone), .progAddr(progAddr), .progData(progData)
  );

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .match(match),
    .blkProtected(blkProtected), .allProtected(allProtected), .engBusy(engBusy),
    .engError(engError), .holdDone(holdDone), .stb(stb), .mode(mode),
    .progStart(progStart), .eraseStart(eraseStart)
  );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              engBusy,
  input logic [1:0]        mode,
  input logic              progStart,
  input logic              eraseStart,
  input logic [ADDR_W-1:0] progAddr,
  input logic [7:0]        progData
);
  p_prog_status_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> mode == 2'd3);

  p_prog_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  p_prog_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (progAddr == $past(wrAddr) && progData == $past(wrData) && $past(wrValid)));

  p_erase_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart && mode == 2'd3);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && engBusy) |=> !progStart && !eraseStart && mode == 2'd3);

  p_single_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, eraseStart}));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
  .engBusy(engBusy), .mode(mode), .progStart(progStart), .eraseStart(eraseStart),
  .progAddr(progAddr), .progData(progData)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int ADDR_W   = 18;
  localparam int HOLD_CYC = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              blkProtected = 1'b0;
  logic              allProtected = 1'b0;
  logic              engBusy = 1'b0;
  logic              engError = 1'b0;
  logic [1:0]        mode;
  logic              progStart, eraseStart;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0]        progData;

  int checks = 0;
  int fails  = 0;
  logic gotProg, gotErase;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .blkProtected(blkProtected), .allProtected(allProtected), .engBusy(engBusy),
    .engError(engError), .mode(mode), .progStart(progStart), .eraseStart(eraseStart),
    .progAddr(progAddr), .progData(progData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus write, presented on a falling edge; outputs sampled one cycle later
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    gotProg = progStart; gotErase = eraseStart;
  endtask

  task automatic unlock();
    wr(18'h00555, 8'hAA);
    wr(18'h002AA, 8'h55);
  endtask

  // engine model: busy from the cycle after a start pulse
  task automatic engine(input int cyc, input logic err);
    engBusy = 1'b1;
    repeat (cyc) @(negedge clk);
    engBusy = 1'b0; engError = err;
    @(negedge clk);
    engError = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mode", mode, 0);
    check("R1 progStart", progStart, 0);
    check("R1 eraseStart", eraseStart, 0);
  endtask

  task automatic t_program();
    unlock(); wr(18'h00555, 8'hA0);
    check("R2 no early start", gotProg, 0);
    wr(18'h12345, 8'h5A);
    check("R2 start", gotProg, 1);
    check("R2 addr", progAddr, 32'h12345);
    check("R2 data", progData, 8'h5A);
    check("R2 status", mode, 3);
    engine(5, 1'b0);
    check("R2 back to read", mode, 0);
  endtask

  task automatic t_highbits();
    wr(18'h3F555, 8'hAA); wr(18'h0A2AA, 8'h55); wr(18'h1D555, 8'h90);
    check("R3 upper bits ignored", mode, 1);
    wr(18'h0, 8'hF0);
  endtask

  task automatic t_deviate();
    wr(18'h00555, 8'hAA); wr(18'h002AB, 8'h55);
    wr(18'h00555, 8'hA0); wr(18'h00100, 8'h11);
    check("R4 broken prefix no start", gotProg, 0);
    check("R4 read", mode, 0);
    unlock(); wr(18'h00555, 8'h90);
    wr(18'h00123, 8'h45);
    check("R4 stray write leaves auto select", mode, 0);
  endtask

  task automatic t_reset_cmd();
    unlock(); wr(18'h00555, 8'h90);
    wr(18'h2ABCD, 8'hF0);
    check("R5 single F0", mode, 0);
    unlock(); wr(18'h00555, 8'h90);
    unlock(); wr(18'h00007, 8'hF0);
    check("R5 unlocked F0", mode, 0);
  endtask

  task automatic t_autosel();
    unlock(); wr(18'h00555, 8'h90);
    check("R6 enter", mode, 1);
    repeat (10) @(negedge clk);
    check("R6 persists", mode, 1);
    wr(18'h0, 8'hF0);
  endtask

  task automatic t_bypass();
    unlock(); wr(18'h00555, 8'h20);
    check("R7 bypass mode", mode, 2);
    wr(18'h3FFFF, 8'hA0); wr(18'h00ABC, 8'hC3);
    check("R7 start", gotProg, 1);
    check("R7 addr", progAddr, 32'h00ABC);
    engine(3, 1'b0);
    check("R7 stays bypass", mode, 2);
    wr(18'h00011, 8'h90); wr(18'h00022, 8'h00);
    check("R8 bypass exit", mode, 0);
  endtask

  task automatic t_protect();
    unlock(); wr(18'h00555, 8'hA0);
    blkProtected = 1'b1; wr(18'h00200, 8'h77); blkProtected = 1'b0;
    check("R9 no start", gotProg, 0);
    check("R9 read", mode, 0);
    unlock(); wr(18'h00555, 8'h20);
    wr(18'h0, 8'hA0);
    blkProtected = 1'b1; wr(18'h00300, 8'h66); blkProtected = 1'b0;
    check("R9 bypass no start", gotProg, 0);
    check("R9 bypass kept", mode, 2);
    wr(18'h0, 8'h90); wr(18'h0, 8'h00);
  endtask

  task automatic t_busy();
    logic seen;
    unlock(); wr(18'h00555, 8'hA0); wr(18'h00040, 8'h12);
    engBusy = 1'b1;
    seen = 1'b0;
    unlock(); seen = seen | gotProg;
    wr(18'h00555, 8'hA0); seen = seen | gotProg;
    wr(18'h00050, 8'h34); seen = seen | gotProg;
    check("R10 no start while busy", seen, 0);
    check("R10 addr unchanged", progAddr, 32'h00040);
    wr(18'h0, 8'hF0);
    check("R10 status kept", mode, 3);
    engBusy = 1'b0;
    @(negedge clk);
    check("R10 released", mode, 0);
  endtask

  task automatic erase_seq();
    logic early;
    early = 1'b0;
    unlock(); early = early | gotErase;
    wr(18'h00555, 8'h80); early = early | gotErase;
    unlock(); early = early | gotErase;
    check("R11 no early erase", early, 0);
    wr(18'h00555, 8'h10);
  endtask

  task automatic t_erase();
    erase_seq();
    check("R11 erase start", gotErase, 1);
    check("R11 status", mode, 3);
    engine(6, 1'b0);
    check("R11 back to read", mode, 0);
  endtask

  task automatic t_allprot();
    int n;
    allProtected = 1'b1;
    erase_seq();
    allProtected = 1'b0;
    check("R12 no erase start", gotErase, 0);
    n = 0;
    while (mode == 2'd3 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R12 hold length", n, HOLD_CYC);
    check("R12 read after hold", mode, 0);
  endtask

  task automatic t_error();
    unlock(); wr(18'h00555, 8'hA0); wr(18'h00060, 8'h00);
    engine(4, 1'b1);
    repeat (3) @(negedge clk);
    check("R13 error holds status", mode, 3);
    wr(18'h00555, 8'hAA);
    check("R13 non-F0 ignored", mode, 3);
    wr(18'h0, 8'hF0);
    check("R13 cleared to read", mode, 0);
    unlock(); wr(18'h00555, 8'h20);
    wr(18'h0, 8'hA0); wr(18'h00070, 8'h01);
    engine(2, 1'b1);
    check("R13 bypass error status", mode, 3);
    wr(18'h0, 8'hF0);
    check("R13 cleared to bypass", mode, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_highbits();
    t_deviate();
    t_reset_cmd();
    t_autosel();
    t_bypass();
    t_protect();
    t_busy();
    t_erase();
    t_allprot();
    t_error();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule